// File: doc/BRIEF.md
# Trace Encoder Control and Message-Loss Handling

This block holds the control word of a processor trace encoder and decides what happens to each trace message when the downstream sink is not ready for it. Software reaches the control word through a simple write strobe with write data and a read-data bus that always shows the current word. The encoder core offers messages on a valid line for each trace channel, and the sink answers on a ready line for each channel. Channel 0 carries instruction trace and channel 1 carries data trace. Both channels use the same logic, and each has its own trigger on and off pulses.

If a channel refuses a message, it follows its stall-enable field. With the field at 0 the message is dropped, and the next accepted message raises a one-cycle overflow-synchronisation request. With the field at 1 the block asks the hart to stall until the sink takes the message. Either event sets that channel's sticky loss flag, which software clears by writing 1. A component-active bit holds the whole block in reset while it is 0. Software polls it to confirm that reset has been entered or left.

Control word layout: bit 0 is the component-active bit and bit 1 is the trace-enable bit. Channel c uses the four bits starting at 4+4c: +0 tracing, +1 trigger-enable, +2 sticky loss flag, +3 stall-enable. All other bits are reserved.

Top module: `tracectl_top`

## Requirements
- R1: After the synchronous reset `rst`, the control word reads 0, and `hart_stall`, `ovf_sync` and `tracing` are all 0.
- R2: A write with bit 0 = 0 puts the component into reset, and from the next cycle the word reads 0. A write with bit 0 = 1 issued while the component is inactive makes bit 0 read 1 from the next cycle.
- R3: While bit 0 reads 0, writes to every other field are ignored. Reserved bits always read 0. Once active, a write of the fields reads back as written, except that the sticky flag reads 0 unless set by hardware.
- R4: A write that takes the trace-enable bit (bit 1) from 0 to 1 clears both channels' sticky flags.
- R5: The sticky flag (bit 4c+6) is set one cycle after a refused message. A write with that bit at 1 clears it, and a write with it at 0 leaves it alone. If a refusal and a clearing write fall in the same cycle, the flag stays set.
- R6: With stall-enable 0, a refused message (valid 1, ready 0, tracing 1, enable 1) is dropped, sets the sticky flag and does not raise `hart_stall`.
- R7: After a drop, the first accepted message on that channel makes `ovf_sync[c]` high for exactly the following cycle. Later accepts raise nothing.
- R8: With stall-enable 1, `hart_stall` is high in each cycle after a refused-message cycle, and it falls in the cycle after the sink accepts.
- R9: With trigger-enable 1, `trig_on[c]` sets and `trig_off[c]` clears tracing on the next cycle. If both pulse in the same cycle, the off pulse wins.
- R10: With trigger-enable 0, trigger pulses leave tracing unchanged.
- R11: A register write sets tracing to the written bit, and it takes priority over a trigger pulse in the same cycle.
- R12: When tracing or trace-enable is 0, messages are ignored: no stall, no sticky flag, and no later overflow request.
- R13: The two channels are independent. Activity on one changes neither the fields nor the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | REG_W | Control word write data |
| cfg_rdata | output | REG_W | Current control word |
| trig_on | input | NUM_CH | Trigger trace-on pulse per channel |
| trig_off | input | NUM_CH | Trigger trace-off pulse per channel |
| msg_valid | input | NUM_CH | Encoder core offers a message, per channel |
| sink_ready | input | NUM_CH | Sink accepts the offered message, per channel |
| hart_stall | output | 1 | Hart stall request |
| ovf_sync | output | NUM_CH | One-cycle overflow-synchronisation request per channel |
| tracing | output | NUM_CH | Current tracing state per channel |

## Verification
The bench builds the block with its defaults: two channels and a 32-bit control word. Two channels is enough to sweep every combination of stall-enable and sink readiness on each channel while checking that the other channel stays untouched. The sweep over trigger-enable, initial tracing state, and every pairing of on and off pulses covers all sixteen trigger cases on both channels. Expected values come from simple arithmetic on the field layout in the requirements.

// File: rtl/tracectl_pkg.sv
package tracectl_pkg;
  // Global control bit positions
  localparam int unsigned ACT_BIT   = 0;
  localparam int unsigned ENA_BIT   = 1;
  // Per-channel field group placement
  localparam int unsigned CH_BASE   = 4;
  localparam int unsigned CH_STRIDE = 4;

  // Per-channel field group, LSB first: tracing, trig_en, sticky, stall_en
  typedef struct packed {
    logic stall_en;
    logic sticky;
    logic trig_en;
    logic tracing;
  } ch_fld_t;
endpackage

// File: rtl/tracectl_glob.sv
module tracectl_glob (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic w_act,
  input  logic w_ena,
  output logic active_q,
  output logic enable_q,
  output logic ch_clr,
  output logic ch_wr,
  output logic en_rise,
  output logic live_en
);
  logic go_inactive;

  assign go_inactive = wr & ~w_act;
  assign ch_clr      = ~active_q | go_inactive;
  assign ch_wr       = wr & active_q & w_act;
  assign en_rise     = ch_wr & w_ena & ~enable_q;
  assign live_en     = active_q & enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      enable_q <= 1'b0;
    end else begin
      if (wr) active_q <= w_act;
      if (!active_q || go_inactive) enable_q <= 1'b0;
      else if (wr)                  enable_q <= w_ena;
    end
  end

  AST_INACTIVE_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !enable_q); // R3
endmodule

// File: rtl/tracectl_chan.sv
module tracectl_chan
  import tracectl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    live_en,
  input  logic    en_rise,
  input  logic    wr,
  input  ch_fld_t wfld,
  input  logic    trig_on,
  input  logic    trig_off,
  input  logic    msg_valid,
  input  logic    sink_ready,
  output ch_fld_t fld_q,
  output logic    stall_q,
  output logic    ovf_q
);
  logic drop_pend_q;
  logic go, refuse, accept;

  assign go     = live_en & fld_q.tracing;
  assign refuse = go & msg_valid & ~sink_ready;
  assign accept = go & msg_valid & sink_ready;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fld_q       <= '0;
      drop_pend_q <= 1'b0;
      stall_q     <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      if (wr)                               fld_q.tracing <= wfld.tracing;
      else if (fld_q.trig_en && trig_off)   fld_q.tracing <= 1'b0;
      else if (fld_q.trig_en && trig_on)    fld_q.tracing <= 1'b1;

      if (wr) begin
        fld_q.trig_en  <= wfld.trig_en;
        fld_q.stall_en <= wfld.stall_en;
      end

      if (refuse)                                fld_q.sticky <= 1'b1;
      else if (en_rise || (wr && wfld.sticky))   fld_q.sticky <= 1'b0;

      if (refuse && !fld_q.stall_en) drop_pend_q <= 1'b1;
      else if (accept)               drop_pend_q <= 1'b0;

      ovf_q   <= accept & drop_pend_q;
      stall_q <= refuse & fld_q.stall_en;
    end
  end

  AST_STALL_ON_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (refuse && fld_q.stall_en && !clr) |=> stall_q); // R8
  AST_DROP_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (refuse && !fld_q.stall_en) |=> !stall_q); // R6
  AST_STICKY_ON_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (refuse && !clr) |=> fld_q.sticky); // R5
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q); // R7
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!fld_q.trig_en && !wr && !clr) |=> $stable(fld_q.tracing)); // R10
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !go |=> !stall_q); // R12
endmodule

// File: rtl/tracectl_top.sv
module tracectl_top
  import tracectl_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [NUM_CH-1:0] trig_on,
  input  logic [NUM_CH-1:0] trig_off,
  input  logic [NUM_CH-1:0] msg_valid,
  input  logic [NUM_CH-1:0] sink_ready,
  output logic              hart_stall,
  output logic [NUM_CH-1:0] ovf_sync,
  output logic [NUM_CH-1:0] tracing
);
  localparam int unsigned FLD_W = $bits(ch_fld_t);

  logic active_q, enable_q, ch_clr, ch_wr, en_rise, live_en;
  ch_fld_t fld [NUM_CH];
  logic [NUM_CH-1:0] stall_v;

  tracectl_glob u_glob (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .w_act    (cfg_wdata[ACT_BIT]),
    .w_ena    (cfg_wdata[ENA_BIT]),
    .active_q (active_q),
    .enable_q (enable_q),
    .ch_clr   (ch_clr),
    .ch_wr    (ch_wr),
    .en_rise  (en_rise),
    .live_en  (live_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned LSB = CH_BASE + c * CH_STRIDE;
    tracectl_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .clr        (ch_clr),
      .live_en    (live_en),
      .en_rise    (en_rise),
      .wr         (ch_wr),
      .wfld       (ch_fld_t'(cfg_wdata[LSB +: FLD_W])),
      .trig_on    (trig_on[c]),
      .trig_off   (trig_off[c]),
      .msg_valid  (msg_valid[c]),
      .sink_ready (sink_ready[c]),
      .fld_q      (fld[c]),
      .stall_q    (stall_v[c]),
      .ovf_q      (ovf_sync[c])
    );
    assign tracing[c] = fld[c].tracing;
  end

  assign hart_stall = |stall_v;

  always_comb begin
    cfg_rdata          = '0;
    cfg_rdata[ACT_BIT] = active_q;
    cfg_rdata[ENA_BIT] = enable_q;
    for (int c = 0; c < NUM_CH; c++)
      cfg_rdata[CH_BASE + c * CH_STRIDE +: FLD_W] = fld[c];
  end
endmodule

// File: tb/tracectl_top_tb.sv
module tracectl_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  trig_on = '0, trig_off = '0, msg_valid = '0, sink_ready = '0;
  logic        hart_stall;
  logic [1:0]  ovf_sync, tracing;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  tracectl_top #(.NUM_CH(2), .REG_W(32)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trig_on(trig_on), .trig_off(trig_off),
    .msg_valid(msg_valid), .sink_ready(sink_ready), .hart_stall(hart_stall),
    .ovf_sync(ovf_sync), .tracing(tracing)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    cfg_wr = 0; trig_on = '0; trig_off = '0; msg_valid = '0; sink_ready = '0;
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_wr = 1; cfg_wdata = d; cyc(); cfg_wr = 0;
  endtask

  function automatic int base(input int c);
    return 4 + 4 * c;
  endfunction

  function automatic logic bitof(input int pos);
    return cfg_rdata[pos];
  endfunction

  initial begin
    cyc(); cyc(); rst = 0; cyc();
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 32'h0);
    chk("R1 outputs", {hart_stall, ovf_sync, tracing}, 5'h0);

    // R3 writes ignored while inactive, R2 activation
    wr(32'hFFFF_FFFE);
    chk("R3 ignored while inactive", cfg_rdata, 32'h0);
    wr(32'hFFFF_FFFF);
    chk("R2 activate reads 1 only", cfg_rdata, 32'h1);
    wr(32'hFFFF_FFFF);
    chk("R3 readback reserved zero", cfg_rdata, 32'h0000_0BB3);
    wr(32'h0);
    chk("R2 deactivate clears word", cfg_rdata, 32'h0);
    chk("R2 tracing cleared", tracing, 2'b00);
    wr(32'h1);
    chk("R2 active reads 1", cfg_rdata, 32'h1);

    // Overflow / stall sweep per channel and stall-enable value
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic [31:0] w, stk;
        int oc;
        oc  = 1 - c;
        w   = 32'h3 | ((32'h1 | (32'(s) << 3)) << base(c));
        stk = 32'h1 << (base(c) + 2);
        wr(32'h0); wr(32'h1); wr(w);
        chk("R3 channel readback", cfg_rdata, w);
        // refused message
        msg_valid[c] = 1; sink_ready[c] = 0; cyc();
        chk("R6/R8 stall on refuse", hart_stall, s);
        chk("R5 sticky set on refuse", bitof(base(c) + 2), 1);
        chk("R7 no ovf on refuse", ovf_sync[c], 0);
        if (s == 1) begin
          cyc();
          chk("R8 stall held", hart_stall, 1);
        end
        // accepted message
        sink_ready[c] = 1; cyc();
        chk("R7 ovf after drop", ovf_sync[c], (s == 0));
        chk("R8 stall released", hart_stall, 0);
        cyc();
        chk("R7 ovf single pulse", ovf_sync[c], 0);
        idle();
        chk("R13 other channel ovf", ovf_sync[oc], 0);
        chk("R13 other channel fields", (cfg_rdata >> base(oc)) & 32'hF, 0);
        // W1C
        wr(w);
        chk("R5 write 0 keeps sticky", bitof(base(c) + 2), 1);
        wr(w | stk);
        chk("R5 write 1 clears sticky", bitof(base(c) + 2), 0);
        // enable rise clears
        msg_valid[c] = 1; cyc(); idle();
        wr(w & ~32'h2);
        chk("R4 enable low keeps sticky", bitof(base(c) + 2), 1);
        wr(w);
        chk("R4 enable rise clears sticky", bitof(base(c) + 2), 0);
        // set wins over clear
        msg_valid[c] = 1; wr(w | stk); idle();
        chk("R5 set wins over clear", bitof(base(c) + 2), 1);
      end
    end

    // R12 messages ignored when not tracing or not enabled
    for (int c = 0; c < 2; c++) begin
      wr(32'h0); wr(32'h1);
      wr(32'h3);
      msg_valid[c] = 1; cyc(); idle(); cyc();
      chk("R12 not tracing no sticky", bitof(base(c) + 2), 0);
      chk("R12 not tracing no stall", hart_stall, 0);
      wr(32'h1 | (32'h1 << base(c)));
      msg_valid[c] = 1; cyc(); idle(); cyc();
      chk("R12 disabled no sticky", bitof(base(c) + 2), 0);
      wr(32'h3 | (32'h1 << base(c)));
      msg_valid[c] = 1; sink_ready[c] = 1; cyc(); idle();
      chk("R12 no ovf without drop", ovf_sync[c], 0);
    end

    // Trigger sweep R9 / R10
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 16; k++) begin
        logic te, init, on, off, exp;
        te = k[3]; init = k[2]; on = k[1]; off = k[0];
        wr(32'h0); wr(32'h1);
        wr(32'h3 | ((32'(init) | (32'(te) << 1)) << base(c)));
        trig_on[c] = on; trig_off[c] = off; cyc(); idle();
        exp = te ? (off ? 1'b0 : (on ? 1'b1 : init)) : init;
        if (te) chk("R9 trigger effect", tracing[c], exp);
        else    chk("R10 trigger ignored", tracing[c], exp);
        chk("R13 other tracing", tracing[1 - c], 0);
      end
      // R11 write wins over trigger
      wr(32'h0); wr(32'h1);
      wr(32'h3 | (32'h2 << base(c)));
      trig_on[c] = 1; wr(32'h3 | (32'h2 << base(c))); idle();
      chk("R11 write beats trace-on", tracing[c], 0);
      wr(32'h3 | (32'h3 << base(c)));
      trig_off[c] = 1; wr(32'h3 | (32'h3 << base(c))); idle();
      chk("R11 write beats trace-off", tracing[c], 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule